// File: doc/BRIEF.md
# Vector Integer Reduction Engine

This block folds the active elements of one vector register group into a single scalar result and writes that result back into element 0 of a destination register. It supports these operations: wrapping sum; bitwise AND, OR and XOR; signed and unsigned minimum and maximum; and signed and unsigned widening sum. The register file it works on holds 128-bit registers. Elements are packed little-endian, and a group of 1, 2, 4 or 8 consecutive registers forms one operand.

The caller sets up the command and pulses `start` while the engine is idle. The engine first reads the seed register, which sets the starting accumulator. It then steps through the source group at one element per clock, reading through a single register-file read port, with an optional per-element mask taken from register 0. On its last cycle it raises `done`. In that same cycle it issues a byte-enabled write that touches only the bytes of destination element 0, and it raises `dirty`. A vector length of zero ends the command with `done` but makes no write and leaves `dirty` low. The engine never resumes a command part-way, so each new command always starts from element 0.

Top module: `vred_engine`

## Requirements
- R1: Element i of a group whose element width is W bytes (W = 1 << `sewSel`, with sewSel 0/1/2/3 = 8/16/32/64 bits) is read from register `srcIdx + i / (16/W)`, at byte offset `(i mod (16/W)) * W`, little-endian.
- R2: The accumulator starts from element 0 of register `seedIdx`, used exactly as stored, with no identity value substituted.
- R3: A write goes to register `dstIdx`, carries the result in the low bytes of `rfWrData`, and enables only the bytes of element 0 (W bytes, or 2W for the widening sums). All other destination bytes keep their old contents.
- R4: `opSel` 0 (sum) wraps modulo 2^SEW, so 200 + 100 at 8 bits gives 44.
- R5: `opSel` 1, 2 and 3 compute the bitwise AND, OR and XOR of the seed and the active elements.
- R6: `opSel` 4 and 6 give the unsigned min and max, and 5 and 7 the signed min and max. At 8 bits, 0x80 against 0x01 gives signed min 0x80 and unsigned min 0x01.
- R7: `opSel` 8 (unsigned) and 9 (signed) sum zero-extended or sign-extended elements into a 2×SEW seed and result. At 8 bits, 0xFF + 0xFF gives 0x01FE unsigned and 0xFFFE signed.
- R8: With `maskEn` high, element i contributes only when `maskBits[i]` is set. `maskBits[i]` is bit i mod 8 of byte i/8 of register 0.
- R9: If every element is masked off, element 0 of the destination still receives the seed and `dirty` is raised.
- R10: With a vector length of zero, `done` rises one cycle after acceptance, no write occurs and `dirty` stays low.
- R11: `start` is accepted only while `busy` is low. For an effective length n>0, `done` is a one-cycle pulse n+2 cycles after the accepting edge. After reset `busy`, `done`, `rfWrEn` and `dirty` are low.
- R12: The effective length is min(`vecLen`, (16/W) << `lmulSel`). Elements beyond the register group are never folded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| opSel | input | 4 | Reduction operation code |
| sewSel | input | 2 | Element width code |
| lmulSel | input | 2 | Group size code (1 << lmulSel registers) |
| vecLen | input | LEN_W | Requested element count |
| maskEn | input | 1 | Enable per-element masking |
| dstIdx | input | RIW | Destination register |
| srcIdx | input | RIW | First register of the source group |
| seedIdx | input | RIW | Register holding the seed in element 0 |
| rfRdIdx | output | RIW | Register-file read address |
| rfRdData | input | 128 | Register-file read data (same cycle) |
| maskBits | input | 128 | Contents of register 0 |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrIdx | output | RIW | Register-file write address |
| rfWrData | output | 128 | Register-file write data |
| rfWrByteEn | output | 16 | Per-byte write enables |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final cycle of a command |
| dirty | output | 1 | Destination was modified |

## Verification
A wrong element index or a wrong group offset reads the wrong bytes. That shows up as a wrong destination element 0 on the very next write, and only for the commands that touch the affected lane, so the random mix varies width, group size and length together. A miscounted length moves the `done` pulse away from n+2 cycles, which is visible at the end of every command. A wrong byte-enable width corrupts the neighbouring destination elements in the same write. The bench catches this because it compares the whole 128-bit register against its own model after each command.

// File: rtl/vred_pkg.sv
package vred_pkg;
  localparam int REG_BITS  = 128;
  localparam int REG_BYTES = REG_BITS / 8;
  localparam int ACC_BITS  = 64;
  localparam int ELEM_MAX  = REG_BYTES * 8;            // e8 with an 8-register group
  localparam int CNT_W     = $clog2(ELEM_MAX + 1);
  localparam int MB_IW     = $clog2(REG_BITS);

  typedef enum logic [3:0] {
    OP_SUM = 4'd0, OP_AND = 4'd1, OP_OR = 4'd2, OP_XOR = 4'd3,
    OP_MINU = 4'd4, OP_MIN = 4'd5, OP_MAXU = 4'd6, OP_MAX = 4'd7,
    OP_WSUMU = 4'd8, OP_WSUM = 4'd9
  } redOp_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEED, ST_RUN, ST_FIN} ctrlState_e;

  typedef struct packed {
    logic             loadSeed;
    logic             fold;
    logic [CNT_W-1:0] elemIdx;
  } dpStrobe_t;
endpackage

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LEN_W    = 16,
  localparam int RIW     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           opSel,
  input  logic [1:0]           sewSel,
  input  logic [1:0]           lmulSel,
  input  logic [LEN_W-1:0]     vecLen,
  input  logic                 maskEn,
  input  logic [RIW-1:0]       dstIdx,
  input  logic [RIW-1:0]       srcIdx,
  input  logic [RIW-1:0]       seedIdx,
  input  logic [REG_BITS-1:0]  maskBits,
  output logic [RIW-1:0]       rdIdx,
  output logic [RIW-1:0]       wrIdx,
  output logic                 busy,
  output logic                 done,
  output logic                 wrEn,
  output dpStrobe_t            strobe,
  output redOp_e               opQ,
  output logic [1:0]           sewQ
);
  ctrlState_e stateQ;
  logic [CNT_W-1:0] idxQ, lenQ;
  logic [LEN_W-1:0] vlmax, effLen;
  logic [CNT_W-1:0] regOff;
  logic maskEnQ, emptyQ;
  logic [RIW-1:0] dstQ, srcQ, seedQ;

  // group capacity: elements per register times group size
  always_comb begin
    vlmax  = (LEN_W'(REG_BYTES) >> sewSel) << lmulSel;
    effLen = (vecLen < vlmax) ? vecLen : vlmax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      idxQ    <= '0;
      lenQ    <= '0;
      opQ     <= OP_SUM;
      sewQ    <= '0;
      maskEnQ <= 1'b0;
      emptyQ  <= 1'b0;
      dstQ    <= '0;
      srcQ    <= '0;
      seedQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (start) begin
          idxQ    <= '0;
          lenQ    <= CNT_W'(effLen);
          opQ     <= redOp_e'(opSel);
          sewQ    <= sewSel;
          maskEnQ <= maskEn;
          dstQ    <= dstIdx;
          srcQ    <= srcIdx;
          seedQ   <= seedIdx;
          emptyQ  <= (effLen == '0);
          stateQ  <= (effLen == '0) ? ST_FIN : ST_SEED;
        end
        ST_SEED: stateQ <= ST_RUN;
        ST_RUN: begin
          idxQ <= idxQ + 1'b1;
          if (idxQ == lenQ - 1'b1) stateQ <= ST_FIN;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    regOff = idxQ >> (3'd4 - {1'b0, sewQ});
    rdIdx  = (stateQ == ST_SEED) ? seedQ : srcQ + RIW'(regOff);
    wrIdx  = dstQ;
    busy   = (stateQ != ST_IDLE);
    done   = (stateQ == ST_FIN);
    wrEn   = done && !emptyQ;
    strobe.loadSeed = (stateQ == ST_SEED);
    strobe.fold     = (stateQ == ST_RUN) && (!maskEnQ || maskBits[idxQ[MB_IW-1:0]]);
    strobe.elemIdx  = idxQ;
  end
endmodule

// File: rtl/vred_datapath.sv
module vred_datapath
  import vred_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  redOp_e               opQ,
  input  logic [1:0]           sewQ,
  input  logic [REG_BITS-1:0]  rdData,
  output logic [REG_BITS-1:0]  wrData,
  output logic [REG_BYTES-1:0] wrByteEn
);
  logic [ACC_BITS-1:0] accQ, rawElem, elemExt, seedExt, nextAcc;
  logic [CNT_W-1:0] lane;
  logic [3:0] byteOff;
  logic [4:0] bsel;
  logic widen, sgnElem, sgnSeed;
  logic [1:0] rwCode;
  logic [3:0] byteCnt;

  function automatic logic [ACC_BITS-1:0] extend(input logic [ACC_BITS-1:0] x,
                                                 input logic [1:0] wc, input logic sgn);
    case (wc)
      2'd0: return {{56{sgn & x[7]}}, x[7:0]};
      2'd1: return {{48{sgn & x[15]}}, x[15:0]};
      2'd2: return {{32{sgn & x[31]}}, x[31:0]};
      default: return x;
    endcase
  endfunction

  always_comb begin
    lane    = strobe.elemIdx & CNT_W'((REG_BYTES >> sewQ) - 1);
    byteOff = 4'(lane << sewQ);
    for (int k = 0; k < ACC_BITS / 8; k++) begin
      bsel = {1'b0, byteOff} + 5'(k);
      rawElem[k*8 +: 8] = (bsel < 5'(REG_BYTES)) ? rdData[bsel[3:0]*8 +: 8] : 8'h00;
    end
    widen   = (opQ == OP_WSUMU) || (opQ == OP_WSUM);
    sgnElem = (opQ == OP_MIN) || (opQ == OP_MAX) || (opQ == OP_WSUM);
    sgnSeed = (opQ == OP_MIN) || (opQ == OP_MAX);
    rwCode  = (widen && sewQ != 2'd3) ? sewQ + 2'd1 : sewQ;
    elemExt = extend(rawElem, sewQ, sgnElem);
    seedExt = extend(rawElem, rwCode, sgnSeed);
    case (opQ)
      OP_AND:  nextAcc = accQ & elemExt;
      OP_OR:   nextAcc = accQ | elemExt;
      OP_XOR:  nextAcc = accQ ^ elemExt;
      OP_MINU: nextAcc = (elemExt < accQ) ? elemExt : accQ;
      OP_MAXU: nextAcc = (elemExt > accQ) ? elemExt : accQ;
      OP_MIN:  nextAcc = ($signed(elemExt) < $signed(accQ)) ? elemExt : accQ;
      OP_MAX:  nextAcc = ($signed(elemExt) > $signed(accQ)) ? elemExt : accQ;
      default: nextAcc = accQ + elemExt;
    endcase
    byteCnt  = 4'd1 << rwCode;
    wrByteEn = (REG_BYTES'(1) << byteCnt) - REG_BYTES'(1);
    wrData   = {{(REG_BITS - ACC_BITS){1'b0}}, accQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                accQ <= '0;
    else if (strobe.loadSeed) accQ <= seedExt;
    else if (strobe.fold)     accQ <= nextAcc;
  end
endmodule

// File: rtl/vred_engine.sv
module vred_engine
  import vred_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LEN_W    = 16,
  localparam int RIW     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           opSel,
  input  logic [1:0]           sewSel,
  input  logic [1:0]           lmulSel,
  input  logic [LEN_W-1:0]     vecLen,
  input  logic                 maskEn,
  input  logic [RIW-1:0]       dstIdx,
  input  logic [RIW-1:0]       srcIdx,
  input  logic [RIW-1:0]       seedIdx,
  output logic [RIW-1:0]       rfRdIdx,
  input  logic [REG_BITS-1:0]  rfRdData,
  input  logic [REG_BITS-1:0]  maskBits,
  output logic                 rfWrEn,
  output logic [RIW-1:0]       rfWrIdx,
  output logic [REG_BITS-1:0]  rfWrData,
  output logic [REG_BYTES-1:0] rfWrByteEn,
  output logic                 busy,
  output logic                 done,
  output logic                 dirty
);
  dpStrobe_t  strobe;
  redOp_e     opQ;
  logic [1:0] sewQ;

  vred_ctrl #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .sewSel(sewSel),
    .lmulSel(lmulSel), .vecLen(vecLen), .maskEn(maskEn), .dstIdx(dstIdx),
    .srcIdx(srcIdx), .seedIdx(seedIdx), .maskBits(maskBits), .rdIdx(rfRdIdx),
    .wrIdx(rfWrIdx), .busy(busy), .done(done), .wrEn(rfWrEn), .strobe(strobe),
    .opQ(opQ), .sewQ(sewQ)
  );

  vred_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opQ(opQ), .sewQ(sewQ),
    .rdData(rfRdData), .wrData(rfWrData), .wrByteEn(rfWrByteEn)
  );

  assign dirty = rfWrEn;
endmodule

// File: rtl/vred_engine_chk.sv
module vred_engine_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] vecLen,
  input logic             rfWrEn,
  input logic [15:0]      rfWrByteEn,
  input logic             busy,
  input logic             done,
  input logic             dirty
);
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r10_empty_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && vecLen == '0) |=> (done && !rfWrEn && !dirty));
  a_r3_write_at_done: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> done);
  a_r3_low_bytes_only: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrByteEn[0] && (((rfWrByteEn + 16'd1) & rfWrByteEn) == 16'd0)
                && $countones(rfWrByteEn) <= 8));
endmodule

bind vred_engine vred_engine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .rfWrEn(rfWrEn),
  .rfWrByteEn(rfWrByteEn), .busy(busy), .done(done), .dirty(dirty)
);

// File: tb/vred_engine_bench.sv
module vred_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, maskEn = 1'b0;
  logic [3:0] opSel = '0;
  logic [1:0] sewSel = '0, lmulSel = '0;
  logic [15:0] vecLen = '0;
  logic [4:0] dstIdx = '0, srcIdx = '0, seedIdx = '0, rfRdIdx, rfWrIdx;
  logic [127:0] rfRdData, maskBits, rfWrData;
  logic [15:0] rfWrByteEn;
  logic rfWrEn, busy, done, dirty;
  logic [127:0] rf [32];
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vred_engine u_vred_engine (.*);

  assign rfRdData = rf[rfRdIdx];
  assign maskBits = rf[0];

  always @(posedge clk)
    if (rfWrEn)
      for (int b = 0; b < 16; b++)
        if (rfWrByteEn[b]) rf[rfWrIdx][b*8 +: 8] <= rfWrData[b*8 +: 8];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] x, input int bits);
    logic [63:0] r = x;
    for (int b = bits; b < 64; b++) r[b] = x[bits-1];
    return r;
  endfunction

  function automatic logic [63:0] getElem(input int base, input int i, input int wb);
    int epr = 16 / wb;
    int r = (base + i / epr) % 32;
    int off = (i % epr) * wb;
    logic [63:0] v = '0;
    for (int b = 0; b < wb; b++) v[b*8 +: 8] = rf[r][(off+b)*8 +: 8];
    return v;
  endfunction

  task automatic putElem(input int base, input int i, input int sew, input logic [63:0] v);
    int wb = 1 << sew;
    int epr = 16 / wb;
    for (int b = 0; b < wb; b++) rf[base + i/epr][((i%epr)*wb + b)*8 +: 8] = v[b*8 +: 8];
  endtask

  // reference fold; returns result masked to its width
  function automatic logic [63:0] refFold(input int op, input int sew, input int n, input bit men,
                                          input int src, input int seed, output int rbytes);
    int wb = 1 << sew;
    int w = wb * 8;
    bit wide = (op >= 8);
    logic [63:0] acc, e;
    rbytes = wide ? 2*wb : wb;
    acc = getElem(seed, 0, rbytes);
    for (int i = 0; i < n; i++) begin
      if (men && !rf[0][i]) continue;
      e = getElem(src, i, wb);
      case (op)
        1: acc = acc & e;
        2: acc = acc | e;
        3: acc = acc ^ e;
        4: acc = (e < acc) ? e : acc;
        5: acc = ($signed(sx(e, w)) < $signed(sx(acc, w))) ? e : acc;
        6: acc = (e > acc) ? e : acc;
        7: acc = ($signed(sx(e, w)) > $signed(sx(acc, w))) ? e : acc;
        9: acc = acc + sx(e, w);
        default: acc = acc + e;
      endcase
      if (rbytes < 8) acc = acc & ((64'd1 << (rbytes*8)) - 64'd1);
    end
    return acc;
  endfunction

  function automatic string opTag(input int op);
    if (op == 0) return "R4";
    if (op <= 3) return "R5";
    if (op <= 7) return "R6";
    return "R7";
  endfunction

  logic [127:0] lastDst;

  task automatic runOp(input int op, input int sew, input int lmul, input int vl, input bit men,
                       input int dst, input int src, input int seed, input string tag);
    int vlmax = (16 >> sew) << lmul;
    int n = (vl < vlmax) ? vl : vlmax;
    int rbytes, k;
    logic [63:0] res;
    logic [127:0] expReg;
    res = refFold(op, sew, n, men, src, seed, rbytes);
    expReg = rf[dst];
    if (n > 0) for (int b = 0; b < rbytes; b++) expReg[b*8 +: 8] = res[b*8 +: 8];
    @(negedge clk);
    opSel = 4'(op); sewSel = 2'(sew); lmulSel = 2'(lmul); vecLen = 16'(vl);
    maskEn = men; dstIdx = 5'(dst); srcIdx = 5'(src); seedIdx = 5'(seed); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 1000) begin @(negedge clk); k++; end
    chk(k == ((n == 0) ? 1 : n + 2), {tag, " R11 latency"}, 128'(k), 128'((n == 0) ? 1 : n + 2));
    chk(dirty == (n > 0), {tag, (n == 0) ? " R10 dirty" : " R9 dirty"}, 128'(dirty), 128'(n > 0));
    @(posedge clk); #1;
    lastDst = rf[dst];
    chk(rf[dst] === expReg, {tag, (n == 0) ? " R10 dst" : " R3 dst"}, rf[dst], expReg);
  endtask

  task automatic lit(input logic [63:0] mask, input logic [63:0] v, input string tag);
    chk((lastDst[63:0] & mask) == v, tag, 128'(lastDst[63:0] & mask), 128'(v));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int r = 0; r < 32; r++) rf[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !rfWrEn && !dirty, "R11 reset state", 128'({busy, done, rfWrEn, dirty}), 128'(0));
    rstN = 1'b1;

    // R4 wrap
    putElem(2, 0, 0, 200); putElem(2, 1, 0, 100); putElem(1, 0, 0, 0);
    runOp(0, 0, 0, 2, 0, 4, 2, 1, "R4"); lit(64'hff, 64'd44, "R4 wrap 200+100");
    // R6 signed vs unsigned
    putElem(2, 0, 0, 8'h80); putElem(2, 1, 0, 8'h01); putElem(1, 0, 0, 8'h7f);
    runOp(5, 0, 0, 2, 0, 4, 2, 1, "R6"); lit(64'hff, 64'h80, "R6 signed min");
    runOp(4, 0, 0, 2, 0, 4, 2, 1, "R6"); lit(64'hff, 64'h01, "R6 unsigned min");
    putElem(1, 0, 0, 0);
    runOp(7, 0, 0, 2, 0, 4, 2, 1, "R6"); lit(64'hff, 64'h01, "R6 signed max");
    runOp(6, 0, 0, 2, 0, 4, 2, 1, "R6"); lit(64'hff, 64'h80, "R6 unsigned max");
    // R7 widening
    putElem(2, 0, 0, 8'hff); putElem(2, 1, 0, 8'hff); putElem(1, 0, 1, 0);
    runOp(8, 0, 0, 2, 0, 4, 2, 1, "R7"); lit(64'hffff, 64'd510, "R7 zero extend");
    runOp(9, 0, 0, 2, 0, 4, 2, 1, "R7"); lit(64'hffff, 64'hfffe, "R7 sign extend");
    putElem(2, 0, 2, 32'h8000_0000); putElem(1, 0, 3, 0);
    runOp(9, 2, 0, 1, 0, 4, 2, 1, "R7"); lit('1, 64'hffff_ffff_8000_0000, "R7 e32 to e64");
    // R1 e16 addressing
    for (int i = 0; i < 8; i++) putElem(2, i, 1, 16'(i + 1));
    putElem(1, 0, 1, 100);
    runOp(0, 1, 0, 8, 0, 4, 2, 1, "R1"); lit(64'hffff, 64'd136, "R1 e16 sum");
    // R5 logic ops
    putElem(2, 0, 0, 8'h0f); putElem(2, 1, 0, 8'h0a); putElem(2, 2, 0, 8'h0c); putElem(2, 3, 0, 8'h0e);
    putElem(1, 0, 0, 8'hff);
    runOp(1, 0, 0, 4, 0, 4, 2, 1, "R5"); lit(64'hff, 64'h08, "R5 and");
    // R8 mask alternating, R9 all masked
    rf[0] = 128'h5;
    for (int i = 0; i < 4; i++) putElem(2, i, 2, 10);
    putElem(1, 0, 2, 5);
    runOp(0, 2, 0, 4, 1, 4, 2, 1, "R8"); lit(64'hffff_ffff, 64'd25, "R8 masked sum");
    rf[0] = '0; putElem(1, 0, 2, 7);
    runOp(0, 2, 0, 4, 1, 4, 2, 1, "R9"); lit(64'hffff_ffff, 64'd7, "R9 seed kept");
    // R2 seed used as stored
    putElem(1, 0, 2, 1);
    runOp(4, 2, 0, 4, 0, 4, 2, 1, "R2"); lit(64'hffff_ffff, 64'd1, "R2 seed wins");
    // R10 zero length
    rf[4] = {4{32'hdead_beef}};
    runOp(0, 2, 0, 0, 0, 4, 2, 1, "R10"); lit('1, {2{32'hdead_beef}}, "R10 untouched");
    // R12 group and clamp
    for (int i = 0; i < 32; i++) putElem(2, i, 0, 1);
    putElem(1, 0, 0, 0);
    runOp(0, 0, 1, 32, 0, 8, 2, 1, "R12"); lit(64'hff, 64'd32, "R12 two-register group");
    runOp(0, 0, 0, 40, 0, 8, 2, 1, "R12"); lit(64'hff, 64'd16, "R12 clamp to group");

    // constrained random mix
    for (int t = 0; t < 400; t++) begin
      int op = $urandom_range(0, 9);
      int sew = (op >= 8) ? $urandom_range(0, 2) : $urandom_range(0, 3);
      int lmul = $urandom_range(0, 3);
      int vlmax = (16 >> sew) << lmul;
      int src = ($urandom_range(0, (32 >> lmul) - 1)) << lmul;
      if (t % 8 == 0) for (int r = 0; r < 32; r++) rf[r] = {$urandom, $urandom, $urandom, $urandom};
      runOp(op, sew, lmul, $urandom_range(0, vlmax + 3), 1'($urandom), $urandom_range(1, 31),
            src, $urandom_range(0, 31), opTag(op));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule